// File: doc/BRIEF.md
# Elementary-Stream Output Port

This block delivers parsed elementary-stream bytes to three external decoders: video, audio and auxiliary. Each decoder has its own source of bytes, presented show-ahead by an internal buffer together with a flag that marks timestamp bytes. A decoder asks for data by holding its active-low request line low. The port then places a byte on an 8-bit data bus that all three decoders share. It frames the byte with that decoder's own active-low strobe, and the decoder latches the byte on the strobe's rising edge.

A separate active-high strobe is raised for the whole transfer of any byte that the source has flagged as a timestamp byte. The audio destination can be switched to a bit-serial mode. In that mode each audio byte goes out on a dedicated serial line as eight strobe pulses, most significant bit first, and the shared bus is left untouched. When more than one decoder is requesting, service rotates round-robin, and the port only moves to another decoder at a byte boundary.

Top module: `es_out_port`

## Requirements
- R1: A destination gets a transfer only while its request line is low and its source signals a byte available. An empty source or a request held high gives no strobe pulse.
- R2: Each strobe pulse lasts exactly 2 clocks. The data (bus or serial line) is in place at least 1 clock before the strobe falls and stays unchanged until at least 1 clock after it rises.
- R3: At most one destination strobe is low at any time. In parallel transfers the delivered byte is the one on the shared bus while that destination's strobe is low.
- R4: The timestamp strobe is high throughout the transfer of a byte whose marker bit is 1, and low for unmarked bytes and while idle.
- R5: With the serial mode input at 1, each audio byte (destination index 1) is sent as 8 strobe pulses on the audio strobe, most significant bit first on the serial line, and the shared bus keeps its previous value.
- R6: Between serial audio bytes the serial line holds the last bit sent, which is the LSB of the last byte.
- R7: While several destinations request and have data, grants rotate: after destination i is served, the next grant goes to the first eligible destination in the order i+1, i+2, … modulo 3. Destination 0 has first priority after reset.
- R8: Exactly one source pop pulse is issued per transferred byte, only for the destination being served.
- R9: After reset all strobes are high, the timestamp strobe is low, the bus and the serial line are 0, and no pop is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| src_valid | input | N_DEST | Per-destination source holds a byte |
| src_data | input | N_DEST*DW | Per-destination head byte, destination i in bits [i*DW +: DW] |
| src_mark | input | N_DEST | Head byte is a timestamp byte |
| src_pop | output | N_DEST | One-clock pulse consuming the head byte |
| dec_req_n | input | N_DEST | Active-low data request from each decoder (0 video, 1 audio, 2 auxiliary) |
| aud_serial | input | 1 | 1 selects bit-serial audio delivery |
| vad_data | output | DW | Shared compressed-data bus |
| strb_n | output | N_DEST | Active-low per-destination data strobe |
| ts_strb | output | 1 | High while a timestamp byte is transferred |
| aud_sdata | output | 1 | Serial audio data line |

## Verification
The situation that is hardest to reach is strict rotation under contention. It only shows when all three destinations request continuously with data queued, so the stimulus fills every source with six bytes and drops all requests in the same cycle. The bench then checks that each served destination is followed by the next one modulo 3 for all eighteen bytes. Serial audio is driven with marked and unmarked bytes to check bit order, the timestamp strobe on each bit, and that the bus is left frozen.

// File: rtl/es_out_pkg.sv
package es_out_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_LOW   = 2'd2,
    PH_HOLD  = 2'd3
  } phase_e;
endpackage

// File: rtl/es_out_seq.sv
module es_out_seq #(
  parameter int SETUP_CLKS = 1,
  parameter int LOW_CLKS   = 2,
  parameter int HOLD_CLKS  = 1,
  parameter int UNITS_W    = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [UNITS_W-1:0] units,
  output logic               idle,
  output logic               low_next,
  output logic               unit_step,
  output logic               done
);
  import es_out_pkg::*;

  localparam int MAXC = (SETUP_CLKS > LOW_CLKS) ?
                        ((SETUP_CLKS > HOLD_CLKS) ? SETUP_CLKS : HOLD_CLKS) :
                        ((LOW_CLKS > HOLD_CLKS) ? LOW_CLKS : HOLD_CLKS);
  localparam int CW = $clog2(MAXC + 1);

  phase_e             state, state_d;
  logic [CW-1:0]      cnt, cnt_d;
  logic [UNITS_W-1:0] left, left_d;

  always_comb begin
    state_d   = state;
    cnt_d     = cnt;
    left_d    = left;
    unit_step = 1'b0;
    done      = 1'b0;
    case (state)
      PH_IDLE: begin
        if (start) begin
          state_d = PH_SETUP;
          cnt_d   = CW'(SETUP_CLKS - 1);
          left_d  = units;
        end
      end
      PH_SETUP: begin
        if (cnt == '0) begin
          state_d = PH_LOW;
          cnt_d   = CW'(LOW_CLKS - 1);
        end else begin
          cnt_d = cnt - 1'b1;
        end
      end
      PH_LOW: begin
        if (cnt == '0) begin
          state_d = PH_HOLD;
          cnt_d   = CW'(HOLD_CLKS - 1);
        end else begin
          cnt_d = cnt - 1'b1;
        end
      end
      default: begin
        if (cnt == '0) begin
          if (left == UNITS_W'(1)) begin
            state_d = PH_IDLE;
            done    = 1'b1;
          end else begin
            state_d   = PH_SETUP;
            cnt_d     = CW'(SETUP_CLKS - 1);
            left_d    = left - 1'b1;
            unit_step = 1'b1;
          end
        end else begin
          cnt_d = cnt - 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= PH_IDLE;
      cnt   <= '0;
      left  <= '0;
    end else begin
      state <= state_d;
      cnt   <= cnt_d;
      left  <= left_d;
    end
  end

  assign idle     = (state == PH_IDLE);
  assign low_next = (state_d == PH_LOW);
endmodule

// File: rtl/es_out_rr_arb.sv
module es_out_rr_arb #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] elig,
  input  logic         take,
  output logic [N-1:0] grant,
  output logic         any
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] last;
  logic [IW-1:0] cidx;
  logic [IW-1:0] gidx;
  int            cand;

  always_comb begin
    grant = '0;
    any   = 1'b0;
    gidx  = '0;
    cidx  = '0;
    cand  = 0;
    for (int o = 1; o <= N; o++) begin
      cand = int'(last) + o;
      if (cand >= N) cand = cand - N;
      cidx = IW'(cand);
      if (!any && elig[cidx]) begin
        any         = 1'b1;
        grant[cidx] = 1'b1;
        gidx        = cidx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last <= IW'(N - 1);
    end else if (take && any) begin
      last <= gidx;
    end
  end
endmodule

// File: rtl/es_out_shift.sv
module es_out_shift #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          shift,
  input  logic [DW-1:0] din,
  output logic          sdata
);
  logic [DW-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh    <= '0;
      sdata <= 1'b0;
    end else if (load) begin
      sdata <= din[DW-1];
      sh    <= {din[DW-2:0], 1'b0};
    end else if (shift) begin
      sdata <= sh[DW-1];
      sh    <= {sh[DW-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/es_out_port.sv
module es_out_port #(
  parameter int N_DEST     = 3,
  parameter int DW         = 8,
  parameter int AUD_IDX    = 1,
  parameter int SETUP_CLKS = 1,
  parameter int LOW_CLKS   = 2,
  parameter int HOLD_CLKS  = 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N_DEST-1:0]    src_valid,
  input  logic [N_DEST*DW-1:0] src_data,
  input  logic [N_DEST-1:0]    src_mark,
  output logic [N_DEST-1:0]    src_pop,
  input  logic [N_DEST-1:0]    dec_req_n,
  input  logic                 aud_serial,
  output logic [DW-1:0]        vad_data,
  output logic [N_DEST-1:0]    strb_n,
  output logic                 ts_strb,
  output logic                 aud_sdata
);
  localparam int UW = $clog2(DW + 1);

  logic [N_DEST-1:0] elig, grant, dest_q;
  logic              any, start, ser_pick;
  logic              seq_idle, low_next, unit_step, done;
  logic [DW-1:0]     sel_data;
  logic              sel_mark;
  logic [UW-1:0]     units;

  assign elig  = src_valid & ~dec_req_n;
  assign start = seq_idle & any;

  es_out_rr_arb #(.N(N_DEST)) arb_i (
    .clk   (clk),
    .rst   (rst),
    .elig  (elig),
    .take  (start),
    .grant (grant),
    .any   (any)
  );

  always_comb begin
    sel_data = '0;
    sel_mark = 1'b0;
    for (int i = 0; i < N_DEST; i++) begin
      if (grant[i]) begin
        sel_data = src_data[i*DW +: DW];
        sel_mark = src_mark[i];
      end
    end
  end

  assign ser_pick = aud_serial & grant[AUD_IDX];
  assign units    = ser_pick ? UW'(DW) : UW'(1);
  assign src_pop  = start ? grant : '0;

  es_out_seq #(
    .SETUP_CLKS (SETUP_CLKS),
    .LOW_CLKS   (LOW_CLKS),
    .HOLD_CLKS  (HOLD_CLKS),
    .UNITS_W    (UW)
  ) seq_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .units     (units),
    .idle      (seq_idle),
    .low_next  (low_next),
    .unit_step (unit_step),
    .done      (done)
  );

  es_out_shift #(.DW(DW)) ser_i (
    .clk   (clk),
    .rst   (rst),
    .load  (start & ser_pick),
    .shift (unit_step),
    .din   (sel_data),
    .sdata (aud_sdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dest_q   <= '0;
      vad_data <= '0;
      ts_strb  <= 1'b0;
      strb_n   <= '1;
    end else begin
      if (start) begin
        dest_q  <= grant;
        ts_strb <= sel_mark;
        if (!ser_pick) vad_data <= sel_data;
      end else if (done) begin
        ts_strb <= 1'b0;
      end
      strb_n <= low_next ? ~dest_q : '1;
    end
  end
endmodule

// File: rtl/es_out_port_chk.sv
module es_out_port_chk #(
  parameter int N_DEST   = 3,
  parameter int DW       = 8,
  parameter int LOW_CLKS = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [N_DEST-1:0] src_valid,
  input logic [N_DEST-1:0] src_pop,
  input logic [N_DEST-1:0] dec_req_n,
  input logic [DW-1:0]     vad_data,
  input logic [N_DEST-1:0] strb_n,
  input logic              ts_strb,
  input logic              aud_sdata
);
  // R3
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~strb_n));

  // R8
  pop_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(src_pop));

  for (genvar i = 0; i < N_DEST; i++) begin : g_dest
    // R1
    pop_eligible_chk: assert property (@(posedge clk) disable iff (rst)
      src_pop[i] |-> (src_valid[i] && !dec_req_n[i]));

    // R2
    setup_stable_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(strb_n[i]) |-> ($stable(vad_data) && $stable(aud_sdata) && $stable(ts_strb)));

    // R2
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(strb_n[i]) |-> ($stable(vad_data) && $stable(aud_sdata) && $stable(ts_strb)));

    if (LOW_CLKS > 1) begin : g_low
      // R2
      low_width_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(strb_n[i]) |=> !strb_n[i]);
    end
  end
endmodule

bind es_out_port es_out_port_chk #(
  .N_DEST   (N_DEST),
  .DW       (DW),
  .LOW_CLKS (LOW_CLKS)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .src_valid (src_valid),
  .src_pop   (src_pop),
  .dec_req_n (dec_req_n),
  .vad_data  (vad_data),
  .strb_n    (strb_n),
  .ts_strb   (ts_strb),
  .aud_sdata (aud_sdata)
);

// File: tb/es_out_port_tb_top.sv
`timescale 1ns/1ps
module es_out_port_tb_top;
  localparam int N = 3;
  localparam int DW = 8;

  logic            clk = 0;
  logic            rst;
  logic [N-1:0]    src_valid, src_mark, src_pop, dec_req_n, strb_n;
  logic [N*DW-1:0] src_data;
  logic            aud_serial, ts_strb, aud_sdata;
  logic [DW-1:0]   vad_data;

  int wr_cnt[N];
  int rd_idx[N];
  int got[N];
  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  es_out_port dut_i (
    .clk(clk), .rst(rst), .src_valid(src_valid), .src_data(src_data),
    .src_mark(src_mark), .src_pop(src_pop), .dec_req_n(dec_req_n),
    .aud_serial(aud_serial), .vad_data(vad_data), .strb_n(strb_n),
    .ts_strb(ts_strb), .aud_sdata(aud_sdata)
  );

  function automatic logic [7:0] gen(int d, int k);
    return 8'((d * 64 + k * 37 + 5) % 256);
  endfunction

  function automatic logic gmark(int k);
    return (k % 3) == 0;
  endfunction

  always_comb begin
    for (int d = 0; d < N; d++) begin
      src_valid[d]          = rd_idx[d] < wr_cnt[d];
      src_data[d*DW +: DW]  = gen(d, rd_idx[d]);
      src_mark[d]           = gmark(rd_idx[d]);
    end
  end

  always @(posedge clk) begin
    for (int d = 0; d < N; d++)
      if (!rst && src_pop[d]) rd_idx[d] <= rd_idx[d] + 1;
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor state
  logic [N-1:0]  prev_strb = '1;
  logic [DW-1:0] prev_bus = '0;
  logic          prev_sd = 0;
  logic [DW-1:0] fall_bus;
  logic          fall_sd;
  int            low_cnt[N];
  int            order[64];
  int            n_order = 0;
  logic [7:0]    acc = 0;
  int            nbit = 0;
  logic [DW-1:0] frozen_bus;
  bit            ser_phase = 0;

  always @(negedge clk) begin
    if (!rst) begin
      for (int d = 0; d < N; d++) begin
        if (!strb_n[d] && prev_strb[d]) begin
          // R2 setup: data already in place the clock before the fall
          chk(vad_data == prev_bus && aud_sdata == prev_sd, "R2", "setup", vad_data, prev_bus);
          fall_bus = vad_data;
          fall_sd  = aud_sdata;
          if (n_order < 64) order[n_order] = d;
          n_order++;
        end
        if (!strb_n[d]) low_cnt[d]++;
        if (strb_n[d] && !prev_strb[d]) begin
          chk(low_cnt[d] == 2, "R2", "strobe low clocks", low_cnt[d], 2);
          chk(vad_data == fall_bus && aud_sdata == fall_sd, "R2", "hold", vad_data, fall_bus);
          low_cnt[d] = 0;
          if (d == 1 && aud_serial) begin
            chk(ts_strb == gmark(got[d]), "R4", "ts strobe on serial bit", ts_strb, gmark(got[d]));
            if (ser_phase) chk(vad_data == frozen_bus, "R5", "bus untouched", vad_data, frozen_bus);
            acc = {acc[6:0], aud_sdata};
            nbit++;
            if (nbit == 8) begin
              chk(acc == gen(d, got[d]), "R5", "serial byte MSB first", acc, gen(d, got[d]));
              got[d]++;
              nbit = 0;
            end
          end else begin
            chk(vad_data == gen(d, got[d]), "R3", "byte on bus", vad_data, gen(d, got[d]));
            chk(ts_strb == gmark(got[d]), "R4", "ts strobe", ts_strb, gmark(got[d]));
            got[d]++;
          end
        end
      end
      // R3 single strobe
      if (!$onehot0(~strb_n)) chk(0, "R3", "several strobes low", int'(~strb_n), 0);
    end
    prev_strb = strb_n;
    prev_bus  = vad_data;
    prev_sd   = aud_sdata;
  end

  task automatic wait_got(int d, int target);
    int t = 0;
    while (got[d] < target && t < 3000) begin
      @(negedge clk);
      t++;
    end
    chk(got[d] >= target, "R1", "bytes delivered", got[d], target);
  endtask

  task automatic quiet(int cycles, string req);
    int lows = 0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      if (strb_n != '1) lows++;
    end
    chk(lows == 0, req, "no strobe expected", lows, 0);
  endtask

  task automatic pops_match(string req);
    for (int d = 0; d < N; d++)
      chk(rd_idx[d] == got[d], req, "pops equal bytes", rd_idx[d], got[d]);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end");
    finish_run();
  end

  initial begin
    for (int d = 0; d < N; d++) begin
      wr_cnt[d] = 0; rd_idx[d] = 0; got[d] = 0; low_cnt[d] = 0;
    end
    rst = 1; dec_req_n = '1; aud_serial = 0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(strb_n == '1, "R9", "strobes", strb_n, 7);
    chk(ts_strb == 0, "R9", "ts", ts_strb, 0);
    chk(vad_data == 0, "R9", "bus", vad_data, 0);
    chk(aud_sdata == 0, "R9", "serial", aud_sdata, 0);
    chk(src_pop == 0, "R9", "pop", src_pop, 0);
    rst = 0;

    // R1: data queued but no request
    for (int d = 0; d < N; d++) wr_cnt[d] = 2;
    quiet(30, "R1");
    for (int d = 0; d < N; d++) begin
      wr_cnt[d] = 0;
      dec_req_n[d] = 0;
    end
    // R1: requests but sources empty
    quiet(30, "R1");
    dec_req_n = 3'b110;
    wr_cnt[0] = 6;
    wait_got(0, 6);
    repeat (4) @(negedge clk);
    chk(ts_strb == 0, "R4", "idle ts low", ts_strb, 0);
    pops_match("R8");

    // R7: full contention
    n_order = 0;
    for (int d = 0; d < N; d++) wr_cnt[d] = wr_cnt[d] + 6;
    dec_req_n = 3'b000;
    wait_got(0, 12); wait_got(1, 6); wait_got(2, 6);
    repeat (4) @(negedge clk);
    chk(n_order == 18, "R7", "grant count", n_order, 18);
    chk(order[0] == 1, "R7", "first after dest 0", order[0], 1);
    for (int i = 1; i < 18; i++)
      chk(order[i] == (order[i-1] + 1) % 3, "R7", "rotation", order[i], (order[i-1] + 1) % 3);
    pops_match("R8");

    // R5/R6: serial audio
    dec_req_n = 3'b101;
    aud_serial = 1;
    @(negedge clk);
    frozen_bus = vad_data;
    ser_phase = 1;
    wr_cnt[1] = wr_cnt[1] + 4;
    wait_got(1, 10);
    repeat (6) @(negedge clk);
    chk(aud_sdata == gen(1, 9)[0], "R6", "serial line holds LSB", aud_sdata, gen(1, 9)[0]);
    chk(vad_data == frozen_bus, "R5", "bus after serial", vad_data, frozen_bus);
    chk(ts_strb == 0, "R4", "idle ts low", ts_strb, 0);
    quiet(10, "R6");
    chk(aud_sdata == gen(1, 9)[0], "R6", "serial line still holds", aud_sdata, gen(1, 9)[0]);
    pops_match("R8");
    ser_phase = 0;

    // back to parallel audio
    aud_serial = 0;
    wr_cnt[1] = wr_cnt[1] + 2;
    wait_got(1, 12);
    pops_match("R8");
    finish_run();
  end
endmodule